// File: doc/BRIEF.md
# Token Role and Lifecycle Controller

This block holds the lifecycle stage and the active login role of a cryptographic token. Each command that arrives decides whether to grant or deny. The device starts in a factory stage. A hand-over command moves it into an officer setup stage. There the security officer prepares the device and installs keys. Setting the first user PIN ends setup for good: the officer is logged out and the device enters the operational stage.

In the operational stage the officer and the user have separate command rights. The officer may only do maintenance. The user may only run signing and encryption. None of the setup commands is granted again. A wipe request is the only route back to the setup stage, and it also drops any login.

Each command is a 4-bit code with a valid strobe. A PIN-match flag comes from an external comparator and is sampled together with login codes. Exactly one response strobe follows each command.

Top module: `token_lifecycle_ctrl`

## Requirements
- R1: After reset the stage output is 0 (factory), the role output is 0 (none), and no response strobe is raised.
- R2: Each cycle with cmd_valid high is followed one cycle later by exactly one cycle of rsp_valid high, carrying rsp_grant. No rsp_valid appears in a cycle that follows no command.
- R3: Code 0 (hand-over) is granted only in the factory stage and moves the stage to 1 (setup). In any other stage it is denied.
- R4: Code 1 (officer login) is permitted in stages 1 and 2, and code 2 (user login) only in stage 2. A login is granted only when pin_match is high in the same cycle. The role becomes 1 (officer) or 2 (user), and any refused login leaves the role at 0.
- R5: Code 3 (logout) always clears the role to 0. It is granted only if a role was active.
- R6: Codes 4 (initialise) and 5 (load keys) are granted only to the officer in stage 1, and change neither stage nor role.
- R7: Code 6 (set user PIN), when issued by the officer in stage 1, is granted. It sets the role to 0 and the stage to 2 (operational).
- R8: In stage 2, codes 4, 5 and 6 are always denied, whatever the role.
- R9: Code 7 (maintenance) is granted only to the officer in stage 2. A logged-in user is denied it.
- R10: Code 8 (sign/encrypt) is granted only to the user in stage 2. A logged-in officer is denied it.
- R11: A wipe request in stage 1 or 2 returns the stage to 1 and the role to 0. A wipe in stage 0 changes nothing. A command in the same cycle as a wipe is denied and has no other effect.
- R12: Codes 9 to 15 are denied and change neither stage nor role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command class code |
| pin_match | input | 1 | PIN comparator result, sampled with login codes |
| wipe_req | input | 1 | Full wipe request |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_grant | output | 1 | 1 = command granted, 0 = denied |
| stage | output | 2 | Lifecycle stage: 0 factory, 1 setup, 2 operational |
| role | output | 2 | Active role: 0 none, 1 officer, 2 user |

## Verification
The hardest states to reach are those after the one-way step to the operational stage. Each has to be built by a full sequence: hand-over, officer login with a matching PIN, then set-PIN. Only from there can the bench show that setup codes stay refused for every role. The bench also makes the officer log in again and checks that maintenance is its only right. A wipe that coincides with a command is driven both in the operational stage and in the factory stage. This shows that the wipe wins, and that the stage-0 wipe leaves the device untouched.

// File: rtl/token_lc_pkg.sv
package token_lc_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {STG_FACTORY = 2'd0, STG_SETUP = 2'd1, STG_OPER = 2'd2} stage_e;
  typedef enum logic [1:0] {ROLE_NONE = 2'd0, ROLE_OFFICER = 2'd1, ROLE_USER = 2'd2} role_e;

  localparam logic [CODE_W-1:0] C_HANDOVER  = 4'd0;
  localparam logic [CODE_W-1:0] C_LOGIN_OFF = 4'd1;
  localparam logic [CODE_W-1:0] C_LOGIN_USR = 4'd2;
  localparam logic [CODE_W-1:0] C_LOGOUT    = 4'd3;
  localparam logic [CODE_W-1:0] C_INIT_DEV  = 4'd4;
  localparam logic [CODE_W-1:0] C_LOAD_KEYS = 4'd5;
  localparam logic [CODE_W-1:0] C_SET_PIN   = 4'd6;
  localparam logic [CODE_W-1:0] C_MAINT     = 4'd7;
  localparam logic [CODE_W-1:0] C_CRYPTO    = 4'd8;

  function automatic logic is_setup_cmd(input logic [CODE_W-1:0] c);
    return (c == C_INIT_DEV) || (c == C_LOAD_KEYS) || (c == C_SET_PIN);
  endfunction

  // Grant decision for a command, ignoring wipe.
  function automatic logic permit(input stage_e s, input role_e r,
                                  input logic [CODE_W-1:0] c, input logic pin);
    logic g;
    g = 1'b0;
    case (c)
      C_HANDOVER:  g = (s == STG_FACTORY);
      C_LOGIN_OFF: g = pin && (s == STG_SETUP || s == STG_OPER);
      C_LOGIN_USR: g = pin && (s == STG_OPER);
      C_LOGOUT:    g = (r != ROLE_NONE);
      C_INIT_DEV, C_LOAD_KEYS, C_SET_PIN:
                   g = (s == STG_SETUP) && (r == ROLE_OFFICER);
      C_MAINT:     g = (s == STG_OPER) && (r == ROLE_OFFICER);
      C_CRYPTO:    g = (s == STG_OPER) && (r == ROLE_USER);
      default:     g = 1'b0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/token_lc_policy.sv
module token_lc_policy
  import token_lc_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              pin_match,
  input  logic              wipe_req,
  input  stage_e            stage_q,
  input  role_e             role_q,
  output logic              grant,
  output logic              ev_handover,
  output logic              ev_pin_set,
  output logic              ev_login_off,
  output logic              ev_login_usr,
  output logic              ev_role_clear,
  output logic              ev_wipe
);
  logic live;
  assign live          = cmd_valid && !wipe_req;
  assign grant         = live && permit(stage_q, role_q, cmd_code, pin_match);
  assign ev_handover   = grant && (cmd_code == C_HANDOVER);
  assign ev_pin_set    = grant && (cmd_code == C_SET_PIN);
  assign ev_login_off  = grant && (cmd_code == C_LOGIN_OFF);
  assign ev_login_usr  = grant && (cmd_code == C_LOGIN_USR);
  assign ev_role_clear = live && ((cmd_code == C_LOGOUT) ||
                                  (cmd_code == C_LOGIN_OFF) ||
                                  (cmd_code == C_LOGIN_USR) || ev_pin_set);
  assign ev_wipe       = wipe_req && (stage_q != STG_FACTORY);
endmodule

// File: rtl/token_lc_stage.sv
module token_lc_stage
  import token_lc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_handover,
  input  logic   ev_pin_set,
  input  logic   ev_wipe,
  output stage_e stage_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)           stage_q <= STG_FACTORY;
    else if (ev_wipe)     stage_q <= STG_SETUP;
    else if (ev_handover) stage_q <= STG_SETUP;
    else if (ev_pin_set)  stage_q <= STG_OPER;
  end

  AST_NO_RETURN_TO_FACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q != STG_FACTORY |=> stage_q != STG_FACTORY);             // R11
  AST_OPER_LEFT_ONLY_BY_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_OPER && !ev_wipe) |=> stage_q == STG_OPER);      // R8
  AST_SETUP_ENTERS_OPER_BY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_SETUP && !ev_pin_set) |=> stage_q != STG_OPER);  // R7
endmodule

// File: rtl/token_lc_role.sv
module token_lc_role
  import token_lc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_login_off,
  input  logic  ev_login_usr,
  input  logic  ev_role_clear,
  input  logic  ev_wipe,
  output role_e role_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)            role_q <= ROLE_NONE;
    else if (ev_wipe)      role_q <= ROLE_NONE;
    else if (ev_login_off) role_q <= ROLE_OFFICER;
    else if (ev_login_usr) role_q <= ROLE_USER;
    else if (ev_role_clear) role_q <= ROLE_NONE;
  end

  AST_ROLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    role_q != 2'd3);                                                  // R4
  AST_ROLE_NEEDS_LOGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q == ROLE_NONE && !ev_login_off && !ev_login_usr) |=> role_q == ROLE_NONE); // R4
  AST_WIPE_DROPS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wipe |=> role_q == ROLE_NONE);                                 // R11
endmodule

// File: rtl/token_lifecycle_ctrl.sv
module token_lifecycle_ctrl
  import token_lc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       pin_match,
  input  logic       wipe_req,
  output logic       rsp_valid,
  output logic       rsp_grant,
  output logic [1:0] stage,
  output logic [1:0] role
);
  stage_e stage_q;
  role_e  role_q;
  logic grant, ev_handover, ev_pin_set, ev_login_off, ev_login_usr, ev_role_clear, ev_wipe;

  token_lc_policy u_policy (
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .pin_match(pin_match),
    .wipe_req(wipe_req), .stage_q(stage_q), .role_q(role_q), .grant(grant),
    .ev_handover(ev_handover), .ev_pin_set(ev_pin_set),
    .ev_login_off(ev_login_off), .ev_login_usr(ev_login_usr),
    .ev_role_clear(ev_role_clear), .ev_wipe(ev_wipe)
  );

  token_lc_stage u_stage (
    .clk(clk), .rst_n(rst_n), .ev_handover(ev_handover),
    .ev_pin_set(ev_pin_set), .ev_wipe(ev_wipe), .stage_q(stage_q)
  );

  token_lc_role u_role (
    .clk(clk), .rst_n(rst_n), .ev_login_off(ev_login_off),
    .ev_login_usr(ev_login_usr), .ev_role_clear(ev_role_clear),
    .ev_wipe(ev_wipe), .role_q(role_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_grant <= grant;
    end
  end

  assign stage = stage_q;
  assign role  = role_q;

  AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);                                         // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !rsp_grant);                         // R2
  AST_OPER_REFUSES_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && stage_q == STG_OPER && is_setup_cmd(cmd_code)) |=> !rsp_grant); // R8
  AST_PIN_SET_LOGOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin_set |=> (role_q == ROLE_NONE && stage_q == STG_OPER));     // R7
  AST_WIPE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wipe_req) |=> !rsp_grant);                          // R11
  AST_CRYPTO_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_CRYPTO && role_q != ROLE_USER) |=> !rsp_grant); // R10
  AST_MAINT_OFFICER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_MAINT && role_q != ROLE_OFFICER) |=> !rsp_grant); // R9
endmodule

// File: tb/token_lifecycle_ctrl_bench.sv
module token_lifecycle_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic pin_match = 1'b0;
  logic wipe_req = 1'b0;
  logic rsp_valid, rsp_grant;
  logic [1:0] stage, role;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  token_lifecycle_ctrl u_token_lifecycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pin_match(pin_match), .wipe_req(wipe_req), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .stage(stage), .role(role)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one command (or a bare wipe when v=0), then check the result
  // visible after the capturing edge.
  task automatic issue(input string req, input bit v, input logic [3:0] code,
                       input bit pin, input bit wipe, input bit exp_g,
                       input logic [1:0] exp_s, input logic [1:0] exp_r);
    @(negedge clk);
    cmd_valid = v; cmd_code = code; pin_match = pin; wipe_req = wipe;
    @(negedge clk);
    cmd_valid = 1'b0; pin_match = 1'b0; wipe_req = 1'b0;
    chk({req, " rsp_valid"}, {7'd0, rsp_valid}, {7'd0, v});
    if (v) chk({req, " grant"}, {7'd0, rsp_grant}, {7'd0, exp_g});
    chk({req, " stage"}, {6'd0, stage}, {6'd0, exp_s});
    chk({req, " role"}, {6'd0, role}, {6'd0, exp_r});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 stage", {6'd0, stage}, 8'd0);
    chk("R1 role", {6'd0, role}, 8'd0);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
  endtask

  task automatic t_factory;
    issue("R4 login in factory", 1, 4'd1, 1, 0, 0, 2'd0, 2'd0);
    issue("R11 wipe in factory", 1, 4'd0, 0, 1, 0, 2'd0, 2'd0);
    issue("R3 handover", 1, 4'd0, 0, 0, 1, 2'd1, 2'd0);
    @(negedge clk);
    chk("R2 single rsp", {7'd0, rsp_valid}, 8'd0);
    issue("R3 handover again", 1, 4'd0, 0, 0, 0, 2'd1, 2'd0);
  endtask

  task automatic t_setup;
    issue("R6 init without login", 1, 4'd4, 0, 0, 0, 2'd1, 2'd0);
    issue("R4 user login in setup", 1, 4'd2, 1, 0, 0, 2'd1, 2'd0);
    issue("R4 officer bad pin", 1, 4'd1, 0, 0, 0, 2'd1, 2'd0);
    issue("R5 logout with no role", 1, 4'd3, 0, 0, 0, 2'd1, 2'd0);
    issue("R4 officer login", 1, 4'd1, 1, 0, 1, 2'd1, 2'd1);
    issue("R6 init device", 1, 4'd4, 0, 0, 1, 2'd1, 2'd1);
    issue("R6 load keys", 1, 4'd5, 0, 0, 1, 2'd1, 2'd1);
    issue("R9 maint in setup", 1, 4'd7, 0, 0, 0, 2'd1, 2'd1);
    issue("R12 unknown code", 1, 4'd12, 0, 0, 0, 2'd1, 2'd1);
    issue("R5 logout", 1, 4'd3, 0, 0, 1, 2'd1, 2'd0);
    issue("R4 officer login again", 1, 4'd1, 1, 0, 1, 2'd1, 2'd1);
    issue("R7 set user pin", 1, 4'd6, 0, 0, 1, 2'd2, 2'd0);
  endtask

  task automatic t_oper;
    issue("R8 init with no role", 1, 4'd4, 0, 0, 0, 2'd2, 2'd0);
    issue("R4 officer relogin", 1, 4'd1, 1, 0, 1, 2'd2, 2'd1);
    issue("R8 officer init", 1, 4'd4, 0, 0, 0, 2'd2, 2'd1);
    issue("R8 officer load keys", 1, 4'd5, 0, 0, 0, 2'd2, 2'd1);
    issue("R8 officer set pin", 1, 4'd6, 0, 0, 0, 2'd2, 2'd1);
    issue("R9 officer maint", 1, 4'd7, 0, 0, 1, 2'd2, 2'd1);
    issue("R10 officer crypto", 1, 4'd8, 0, 0, 0, 2'd2, 2'd1);
    issue("R4 user bad pin clears", 1, 4'd2, 0, 0, 0, 2'd2, 2'd0);
    issue("R4 user login", 1, 4'd2, 1, 0, 1, 2'd2, 2'd2);
    issue("R10 user crypto", 1, 4'd8, 0, 0, 1, 2'd2, 2'd2);
    issue("R9 user maint", 1, 4'd7, 0, 0, 0, 2'd2, 2'd2);
    issue("R8 user init", 1, 4'd4, 0, 0, 0, 2'd2, 2'd2);
    issue("R12 unknown code 15", 1, 4'd15, 1, 0, 0, 2'd2, 2'd2);
    issue("R3 handover in oper", 1, 4'd0, 0, 0, 0, 2'd2, 2'd2);
  endtask

  task automatic t_wipe;
    issue("R11 crypto with wipe", 1, 4'd8, 0, 1, 0, 2'd1, 2'd0);
    issue("R11 officer login after wipe", 1, 4'd1, 1, 0, 1, 2'd1, 2'd1);
    issue("R11 init after wipe", 1, 4'd4, 0, 0, 1, 2'd1, 2'd1);
    issue("R11 bare wipe in setup", 0, 4'd0, 0, 1, 0, 2'd1, 2'd0);
    @(negedge clk);
    chk("R2 no rsp after bare wipe", {7'd0, rsp_valid}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_factory();
    t_setup();
    t_oper();
    t_wipe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule